// File: doc/BRIEF.md
# Vertical Blanking Window Generator

This block tracks the line position within a video frame and drives two vertical gates for a video encoder. One is the vertical blank sent out of the chip. The other tells the pixel input path which lines to discard. A line counter clears at the VSYNC leading edge that opens an odd field and keeps counting through the following even field. A single window is programmed once, as odd-field line numbers. The block places the even-field copy of that window itself, using an offset that depends on whether the 525-line or the 625-line standard is selected.

The window is programmed through byte writes at fixed sub-addresses. New values are staged and only reach the comparators at the next VSYNC leading edge, so a field is never blanked with a mix of old and new limits. When the input is noninterlaced, the input gate uses its own window with no even-field offset, while the blank output keeps the interlaced rule. When the blank pin is not used as an output, the window has no effect and both gates stay low.

Top module: `vblank_window_gen`

## Requirements
- R1: After reset both outputs are 0. The active window starts at line 259 and ends at line 19.
- R2: The line count clears to 0 at a VSYNC rising edge when `field_odd_i`=1. A VSYNC rising edge with `field_odd_i`=0 leaves the count unchanged. Each line strobe adds 1, and the count saturates at 1023.
- R3: A write to sub-address 0x23 sets start bits 7:0. A write to 0x24 sets start bit 8 from data bit 0, and data bits 7:1 are ignored. A write to 0x25 sets the 8-bit end line. Writes to any other sub-address change nothing.
- R4: While enabled, the blank flag sets on the clock after the count equals the start line, and clears on the clock after it equals the end line. It holds between those lines, so the window can wrap across a field boundary.
- R5: The same set and clear also happen at start+262 and end+262 when `std_625_i`=0, and at start+313 and end+313 when `std_625_i`=1.
- R6: Written values have no effect on the outputs until the next VSYNC rising edge of either field parity.
- R7: With `prog_in_i`=0, `in_ignore_o` equals `vblank_o`. With `prog_in_i`=1, `in_ignore_o` follows a separate flag that sets at count==start and clears at count==end, with no offset.
- R8: While `blank_out_en_i`=0, both outputs are 0 and both flags are cleared. After the enable returns, a flag sets again only at a later start-line match.
- R9: When the count matches a clear point and a set point together (start equal to end), the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync; its rising edge marks a field start |
| line_stb_i | input | 1 | One-cycle strobe per video line |
| field_odd_i | input | 1 | 1 when the field starting at this VSYNC is odd |
| std_625_i | input | 1 | 0 selects 525-line offset (262), 1 selects 625-line offset (313) |
| prog_in_i | input | 1 | Noninterlaced input mode |
| blank_out_en_i | input | 1 | Blank pin is used as an output |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write sub-address |
| wr_data_i | input | 8 | Write data |
| vblank_o | output | 1 | Vertical blank |
| in_ignore_o | output | 1 | Discard pixel input on this line |

## Verification
The count register updates on the clock edge that samples a line strobe or a VSYNC rising edge, and the window flags follow one edge later. Both outputs are therefore settled two rising edges after a stimulus is sampled. Each driver task holds its stimulus for one cycle, then waits two falling edges before it pushes the expected pair. The monitor compares the outputs at that falling edge, midway between rising edges. Writes push an unchanged expectation, which checks that staged values stay invisible until the next VSYNC.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int START_W = 9;
  localparam int END_W   = 8;

  localparam logic [ADDR_W-1:0] SA_START_LO = 8'h23;
  localparam logic [ADDR_W-1:0] SA_START_HI = 8'h24;
  localparam logic [ADDR_W-1:0] SA_END      = 8'h25;

  localparam logic [START_W-1:0] RST_START = 9'd259;
  localparam logic [END_W-1:0]   RST_END   = 8'd19;

  typedef struct packed {
    logic [START_W-1:0] first_line;
    logic [END_W-1:0]   last_line;
  } win_cfg_t;
endpackage

// File: rtl/vbw_regs.sv
module vbw_regs
  import vbw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  output win_cfg_t          active_o
);
  win_cfg_t pend_d, pend_q, act_d, act_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        SA_START_LO: pend_d.first_line[DATA_W-1:0] = wr_data_i;
        SA_START_HI: pend_d.first_line[START_W-1]  = wr_data_i[0];
        SA_END:      pend_d.last_line              = wr_data_i;
        default:     pend_d = pend_q;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    if (commit_i) act_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '{first_line: RST_START, last_line: RST_END};
      act_q  <= '{first_line: RST_START, last_line: RST_END};
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/vbw_line_cnt.sv
module vbw_line_cnt #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [LINE_W-1:0] cnt_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                        cnt_d = '0;
    else if (step_i && cnt_q != CNT_MAX) cnt_d = cnt_q + LINE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vbw_window.sv
module vbw_window #(
  parameter int LINE_W     = 10,
  parameter bit USE_OFFSET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [LINE_W-1:0] cnt_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic [LINE_W-1:0] clr_line_i,
  input  logic [LINE_W-1:0] offset_i,
  output logic              flag_o
);
  logic set_hit, clr_hit;
  logic flag_d, flag_q;

  generate
    if (USE_OFFSET) begin : g_two_fields
      logic [LINE_W-1:0] set_even, clr_even;
      assign set_even = set_line_i + offset_i;
      assign clr_even = clr_line_i + offset_i;
      assign set_hit  = (cnt_i == set_line_i) || (cnt_i == set_even);
      assign clr_hit  = (cnt_i == clr_line_i) || (cnt_i == clr_even);
    end else begin : g_one_frame
      logic unused_off;
      assign unused_off = ^offset_i;
      assign set_hit    = (cnt_i == set_line_i);
      assign clr_hit    = (cnt_i == clr_line_i);
    end
  endgenerate

  // clear has priority over set when both lines coincide
  always_comb begin
    flag_d = flag_q;
    if (!enable_i)    flag_d = 1'b0;
    else if (clr_hit) flag_d = 1'b0;
    else if (set_hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vblank_window_gen.sv
module vblank_window_gen
  import vbw_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int OFF_525 = 262,
  parameter int OFF_625 = 313
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              line_stb_i,
  input  logic              field_odd_i,
  input  logic              std_625_i,
  input  logic              prog_in_i,
  input  logic              blank_out_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              vblank_o,
  output logic              in_ignore_o
);
  localparam logic [LINE_W-1:0] OFS_A = LINE_W'(OFF_525);
  localparam logic [LINE_W-1:0] OFS_B = LINE_W'(OFF_625);

  logic rst_meta_q, rst_n_s;
  logic vsync_q;
  logic vs_edge, odd_start;
  logic [LINE_W-1:0] line_cnt, offset, set_line, clr_line;
  logic blank_flag, gate_flag;
  win_cfg_t cfg;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) vsync_q <= 1'b0;
    else          vsync_q <= vsync_i;
  end

  assign vs_edge   = vsync_i & ~vsync_q;
  assign odd_start = vs_edge & field_odd_i;

  vbw_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .commit_i (vs_edge),
    .active_o (cfg)
  );

  vbw_line_cnt #(.LINE_W(LINE_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clear_i(odd_start),
    .step_i (line_stb_i),
    .cnt_o  (line_cnt)
  );

  assign offset   = std_625_i ? OFS_B : OFS_A;
  assign set_line = LINE_W'(cfg.first_line);
  assign clr_line = LINE_W'(cfg.last_line);

  vbw_window #(.LINE_W(LINE_W), .USE_OFFSET(1'b1)) u_blank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .enable_i  (blank_out_en_i),
    .cnt_i     (line_cnt),
    .set_line_i(set_line),
    .clr_line_i(clr_line),
    .offset_i  (offset),
    .flag_o    (blank_flag)
  );

  vbw_window #(.LINE_W(LINE_W), .USE_OFFSET(1'b0)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .enable_i  (blank_out_en_i),
    .cnt_i     (line_cnt),
    .set_line_i(set_line),
    .clr_line_i(clr_line),
    .offset_i  (offset),
    .flag_o    (gate_flag)
  );

  assign vblank_o    = blank_flag & blank_out_en_i;
  assign in_ignore_o = blank_out_en_i & (prog_in_i ? gate_flag : blank_flag);
endmodule

// File: rtl/vbw_checker.sv
module vbw_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vsync_i,
  input logic              field_odd_i,
  input logic              line_stb_i,
  input logic              blank_out_en_i,
  input logic [LINE_W-1:0] cnt,
  input logic              blank_q,
  input logic              gate_q,
  input logic [16:0]       cfg
);
  logic vs_prev;
  logic vs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_prev <= 1'b0;
    else         vs_prev <= vsync_i;
  end

  assign vs_rise = vsync_i && !vs_prev;

  // R2: odd-field VSYNC edge zeroes the count
  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise && field_odd_i) |=> (cnt == '0));

  // R2: one line strobe advances the count by one below saturation
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_stb_i && !(vs_rise && field_odd_i) && cnt != '1) |=> (cnt == $past(cnt) + LINE_W'(1)));

  // R2: count holds without a strobe or an odd-field edge
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_stb_i && !(vs_rise && field_odd_i)) |=> $stable(cnt));

  // R6: active window only changes at a VSYNC rising edge
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_rise |=> $stable(cfg));

  // R8: disabling clears both flags
  p_flags_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_out_en_i |=> (!blank_q && !gate_q));
endmodule

bind vblank_window_gen vbw_checker #(.LINE_W(LINE_W)) u_vbw_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_n_s),
  .vsync_i       (vsync_i),
  .field_odd_i   (field_odd_i),
  .line_stb_i    (line_stb_i),
  .blank_out_en_i(blank_out_en_i),
  .cnt           (line_cnt),
  .blank_q       (blank_flag),
  .gate_q        (gate_flag),
  .cfg           (cfg)
);

// File: tb/test_vblank_window_gen.sv
module test_vblank_window_gen;
  logic clk = 1'b0;
  logic rst_ni, vsync_i, line_stb_i, field_odd_i, std_625_i, prog_in_i;
  logic blank_out_en_i, wr_en_i;
  logic [7:0] wr_addr_i, wr_data_i;
  logic vblank_o, in_ignore_o;

  always #10 clk = ~clk;  // 50 MHz

  vblank_window_gen i_vblank_window_gen (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync_i), .line_stb_i(line_stb_i),
    .field_odd_i(field_odd_i), .std_625_i(std_625_i), .prog_in_i(prog_in_i),
    .blank_out_en_i(blank_out_en_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .vblank_o(vblank_o), .in_ignore_o(in_ignore_o)
  );

  typedef struct {
    bit    b;
    bit    g;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  // reference state, built from the requirements
  int mcnt = 0, ps = 259, pe = 19, as_ = 259, ae = 19;
  bit mb = 0, mg = 0;

  function automatic void eval();
    int off = std_625_i ? 313 : 262;
    bit sb = (mcnt == as_) || (mcnt == as_ + off);
    bit cb = (mcnt == ae) || (mcnt == ae + off);
    if (!blank_out_en_i || cb) mb = 0; else if (sb) mb = 1;
    if (!blank_out_en_i || mcnt == ae) mg = 0; else if (mcnt == as_) mg = 1;
  endfunction

  function automatic void push();
    exp_t e;
    e.b   = blank_out_en_i & mb;
    e.g   = blank_out_en_i & (prog_in_i ? mg : mb);
    e.tag = tag;
    sb_q.push_back(e);
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic line(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_stb_i = 1'b1;
      @(negedge clk) line_stb_i = 1'b0;
      if (mcnt < 1023) mcnt++;
      eval();
      @(negedge clk);
      push();
    end
  endtask

  task automatic vsync(bit odd);
    @(negedge clk) begin vsync_i = 1'b1; field_odd_i = odd; end
    @(negedge clk) vsync_i = 1'b0;
    if (odd) mcnt = 0;
    as_ = ps; ae = pe;
    eval();
    @(negedge clk);
    push();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk) begin wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; end
    @(negedge clk) wr_en_i = 1'b0;
    if (a == 8'h23) ps = (ps & 256) | d;
    else if (a == 8'h24) ps = (ps & 255) | (int'(d[0]) << 8);
    else if (a == 8'h25) pe = d;
    eval();
    @(negedge clk);
    push();
  endtask

  task automatic set_en(bit v);
    @(negedge clk) blank_out_en_i = v;
    eval();
    settle();
    eval();
    push();
  endtask

  // monitor: compares each expectation at the time it is pushed
  initial forever begin
    exp_t e;
    wait (sb_q.size() != 0);
    e = sb_q.pop_front();
    n_chk++;
    if (vblank_o !== e.b || in_ignore_o !== e.g) begin
      n_fail++;
      $display("FAIL %s cnt=%0d: vblank/ignore actual %b/%b expected %b/%b",
               e.tag, mcnt, vblank_o, in_ignore_o, e.b, e.g);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; vsync_i = 1'b0; line_stb_i = 1'b0; field_odd_i = 1'b1;
    std_625_i = 1'b0; prog_in_i = 1'b0; blank_out_en_i = 1'b1;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1"; push();                       // R1: outputs low out of reset

    // R1/R4: default window over an odd field, 525-line timing
    tag = "R1/R4"; vsync(1); line(261);
    tag = "R5";    vsync(0); line(263);
    // R5: 625-line offset
    @(negedge clk) std_625_i = 1'b1;
    tag = "R4"; vsync(1); line(312);
    tag = "R5"; vsync(0); line(313);

    // R3/R6: staged writes, reserved bits, stray sub-address
    tag = "R6";
    wr(8'h23, 8'h20); wr(8'h24, 8'hFE); wr(8'h25, 8'h40); wr(8'h26, 8'h01);
    line(3);
    tag = "R3"; vsync(1); line(120);
    tag = "R5"; vsync(0); line(300);

    // R3: high start bit via 0x24 bit 0
    tag = "R3"; wr(8'h23, 8'h08); wr(8'h24, 8'h03); wr(8'h25, 8'h10);
    vsync(1); line(300);

    // R7: noninterlaced input gating
    @(negedge clk) begin prog_in_i = 1'b1; std_625_i = 1'b0; end
    tag = "R7"; wr(8'h23, 8'h0A); wr(8'h24, 8'h00); wr(8'h25, 8'h30);
    vsync(1); line(320);
    vsync(0); line(40);

    // R8: disable forces outputs low and clears flags
    tag = "R8"; vsync(1); line(12);
    set_en(1'b0); line(5);
    set_en(1'b1); line(40);
    @(negedge clk) prog_in_i = 1'b0;

    // R9: start equal to end never blanks
    tag = "R9"; wr(8'h23, 8'h32); wr(8'h25, 8'h32);
    vsync(1); line(330);

    // R2: even edge keeps counting, count saturates
    tag = "R2"; wr(8'h23, 8'h05); wr(8'h25, 8'h1E);
    @(negedge clk) std_625_i = 1'b1;
    vsync(1); line(200); vsync(0); line(1000);

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule